// File: doc/BRIEF.md
# Instruction Fetch Address Translation Stage

This block translates one instruction-fetch virtual address per accepted request. It sits between the fetch unit and an external TLB. Each request carries the address, the current privilege mode, a superpage enable, an address-space number and a misspeculation flag. The stage decides which path the address takes:

- a privileged-library bypass, selected by PC bit 0;
- a rejection for a non-canonical address;
- a kernel-only superpage window;
- a TLB lookup followed by an execute-permission check indexed by mode.

It returns a physical address, an uncacheable flag and a fault code.

The TLB port is combinational. While a request is presented, the stage drives the page number and address-space number, and the TLB answers in the same cycle with a hit flag, a page frame and a four-bit permission vector.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through one output register. The input is ready whenever that register is empty or is being drained this cycle. A held result stays unchanged until it is taken, so back-pressure propagates to the fetch side with no extra buffering.

Every accepted request that faults and is not misspeculated loads two fault registers: the faulting PC, and a page-table entry address formed from a base input and the page number.

Top module: `iatu_fetch_xlate`

## Requirements
- R1: A request whose address has bit 0 set bypasses translation. The result is address bits 39:0 with bits 1:0 cleared, fault code 0 (none) and uncacheable 0, even when the address is non-canonical.
- R2: For a request without the bypass, address bits 63:42 must be all zeros or all ones. Otherwise the result carries fault code 1 (access violation).
- R3: When the superpage enable is 1 and address bits 42:41 equal 2'b10, a request in mode 0 (kernel) gets address bits 39:0 unchanged as its physical address. The TLB is not queried (tlb_lookup stays 0).
- R4: A superpage-window request in any mode other than 0 gets fault code 1.
- R5: A mapped request for which the TLB reports no hit gets fault code 2 (miss). During such a lookup, tlb_vpn equals address bits 42:13.
- R6: On a TLB hit, the physical address is the page frame in bits 39:13 and address bits 12:2 in bits 12:2, with bits 1:0 zero.
- R7: On a TLB hit, bit [mode] of the permission vector must be 1. Otherwise the result gets fault code 1.
- R8: A successful superpage or TLB result with physical bit 39 set has uncacheable = 1; otherwise uncacheable is 0.
- R9: An accepted request with a nonzero fault code loads fault_tag with its address and fault_form with pt_base OR (address bits 42:13 shifted left by 3).
- R10: An accepted faulting request with in_misspec = 1 leaves fault_tag and fault_form unchanged.
- R11: in_ready equals !out_valid || out_ready. While out_valid = 1 and out_ready = 0, the held result does not change.
- R12: After reset, out_valid, fault_tag and fault_form are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_va | input | 64 | Fetch virtual address |
| in_mode | input | 2 | Privilege mode, 0 = kernel |
| in_sp_en | input | 1 | Superpage window enable |
| in_asn | input | 8 | Address-space number |
| in_misspec | input | 1 | Request is misspeculated |
| pt_base | input | 64 | Page-table base for the formatted fault address |
| tlb_lookup | output | 1 | TLB lookup requested this cycle |
| tlb_vpn | output | 30 | Virtual page number for lookup |
| tlb_asn | output | 8 | Address-space number for lookup |
| tlb_hit | input | 1 | TLB hit |
| tlb_pfn | input | 27 | Page frame of the hit entry |
| tlb_perm | input | 4 | Execute permission per mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_pa | output | 40 | Physical address |
| out_uncached | output | 1 | Result is uncacheable |
| out_fault | output | 2 | 0 none, 1 access violation, 2 miss |
| fault_tag | output | 64 | Latched faulting PC |
| fault_form | output | 64 | Latched formatted page-table address |

## Verification
The bench builds the block with its default parameters: a 64-bit address, 43 implemented virtual bits, 40 physical bits, 8 KiB pages and four modes. With these values the superpage window falls on bits 42:41 and the uncacheable flag on bit 39, so the vectors can place addresses exactly on the sign-extension edge and on the uncached bit. The four modes let every permission bit be tested for both granting and denying.

// File: rtl/iatu_pkg.sv
package iatu_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_MISS = 2'd2
  } fault_e;
endpackage

// File: rtl/iatu_va_decode.sv
module iatu_va_decode #(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 43
) (
  input  logic [ADDR_W-1:0] va,
  input  logic              win_en,
  output logic              canonical,
  output logic              in_window
);
  localparam int EXT_W = ADDR_W - VA_W + 1;

  logic [EXT_W-1:0] ext_bits;
  assign ext_bits  = va[ADDR_W-1:VA_W-1];
  // upper bits must replicate the top implemented bit
  assign canonical = (&ext_bits) | ~(|ext_bits);
  assign in_window = win_en && (va[VA_W-1:VA_W-2] == 2'b10);
endmodule

// File: rtl/iatu_perm_check.sv
module iatu_perm_check #(
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0]      mode,
  input  logic [(1<<MODE_W)-1:0] perm,
  output logic                   allowed
);
  localparam int NMODES = 1 << MODE_W;

  logic [NMODES-1:0] sel;
  for (genvar i = 0; i < NMODES; i++) begin : g_sel
    assign sel[i] = (mode == MODE_W'(i));
  end
  assign allowed = |(sel & perm);
endmodule

// File: rtl/iatu_fault_regs.sv
module iatu_fault_regs #(
  parameter int ADDR_W = 64,
  parameter int VPN_W  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              misspec,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] pt_base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] tag_q,
  output logic [ADDR_W-1:0] form_q
);
  localparam int PAD_W = ADDR_W - VPN_W - 3;

  logic [ADDR_W-1:0] form_d;
  assign form_d = pt_base | {{PAD_W{1'b0}}, vpn, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      form_q <= '0;
    end else if (capture && !misspec) begin
      tag_q  <= va;
      form_q <= form_d;
    end
  end

  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    capture && !misspec |=> tag_q == $past(va));
  p_misspec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capture && misspec |=> $stable(tag_q) && $stable(form_q));
endmodule

// File: rtl/iatu_fetch_xlate.sv
module iatu_fetch_xlate #(
  parameter int ADDR_W      = 64,
  parameter int VA_W        = 43,
  parameter int PA_W        = 40,
  parameter int PAGE_W      = 13,
  parameter int MODE_W      = 2,
  parameter int ASN_W       = 8,
  parameter int KERNEL_MODE = 0,
  localparam int VPN_W      = VA_W - PAGE_W,
  localparam int PFN_W      = PA_W - PAGE_W,
  localparam int NMODES     = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_va,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              in_sp_en,
  input  logic [ASN_W-1:0]  in_asn,
  input  logic              in_misspec,
  input  logic [ADDR_W-1:0] pt_base,
  output logic              tlb_lookup,
  output logic [VPN_W-1:0]  tlb_vpn,
  output logic [ASN_W-1:0]  tlb_asn,
  input  logic              tlb_hit,
  input  logic [PFN_W-1:0]  tlb_pfn,
  input  logic [NMODES-1:0] tlb_perm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_pa,
  output logic              out_uncached,
  output logic [1:0]        out_fault,
  output logic [ADDR_W-1:0] fault_tag,
  output logic [ADDR_W-1:0] fault_form
);
  import iatu_pkg::*;

  logic canonical, in_window, perm_ok, is_kernel, fire;
  logic [PA_W-1:0] pa_direct, pa_bypass, pa_mapped;
  fault_e          nxt_fault;
  logic [PA_W-1:0] nxt_pa;
  logic            nxt_unc, need_tlb;

  iatu_va_decode #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_decode (
    .va(in_va), .win_en(in_sp_en), .canonical(canonical), .in_window(in_window)
  );

  iatu_perm_check #(.MODE_W(MODE_W)) u_perm (
    .mode(in_mode), .perm(tlb_perm), .allowed(perm_ok)
  );

  assign is_kernel = (in_mode == MODE_W'(KERNEL_MODE));
  assign pa_direct = in_va[PA_W-1:0];
  assign pa_bypass = {in_va[PA_W-1:2], 2'b00};
  assign pa_mapped = {tlb_pfn, in_va[PAGE_W-1:2], 2'b00};

  // path priority: bypass, canonical check, superpage, TLB
  always_comb begin
    nxt_fault = FLT_NONE;
    nxt_pa    = pa_bypass;
    nxt_unc   = 1'b0;
    need_tlb  = 1'b0;
    if (in_va[0]) begin
      nxt_pa = pa_bypass;
    end else if (!canonical) begin
      nxt_fault = FLT_ACV;
      nxt_pa    = pa_direct;
    end else if (in_window) begin
      nxt_pa = pa_direct;
      if (!is_kernel) nxt_fault = FLT_ACV;
      else            nxt_unc   = pa_direct[PA_W-1];
    end else begin
      need_tlb = 1'b1;
      nxt_pa   = pa_mapped;
      if (!tlb_hit)      nxt_fault = FLT_MISS;
      else if (!perm_ok) nxt_fault = FLT_ACV;
      else               nxt_unc   = pa_mapped[PA_W-1];
    end
  end

  assign tlb_lookup = in_valid && need_tlb;
  assign tlb_vpn    = in_va[VA_W-1:PAGE_W];
  assign tlb_asn    = in_asn;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_pa       <= '0;
      out_uncached <= 1'b0;
      out_fault    <= FLT_NONE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pa       <= nxt_pa;
        out_uncached <= nxt_unc;
        out_fault    <= nxt_fault;
      end
    end
  end

  iatu_fault_regs #(.ADDR_W(ADDR_W), .VPN_W(VPN_W)) u_fregs (
    .clk(clk), .rst_n(rst_n),
    .capture(fire && (nxt_fault != FLT_NONE)),
    .misspec(in_misspec),
    .va(in_va), .pt_base(pt_base), .vpn(tlb_vpn),
    .tag_q(fault_tag), .form_q(fault_form)
  );

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pa)
      && $stable(out_fault) && $stable(out_uncached));
  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_va[0] |=> out_fault == FLT_NONE && !out_uncached);
  p_sp_notlb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_va[0] && canonical && in_window |-> !tlb_lookup);
  p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_fault != 2'd3);
endmodule

// File: tb/test_iatu_fetch_xlate.sv
`timescale 1ns/1ps
module test_iatu_fetch_xlate;
  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  mode;
    logic        sp;
    logic        ms;
    logic        hit;
    logic [26:0] pfn;
    logic [3:0]  perm;
    logic        exp_lk;
    logic [1:0]  exp_flt;
    logic [39:0] exp_pa;
    logic        exp_unc;
    logic [63:0] exp_form;
  } vec_t;

  localparam logic [63:0] PTB = 64'h0000_1000_0000_0000;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R1 bypass, high bits kept in range
    '{64'h0000_0012_3456_7893, 2'd3, 1'b0, 1'b0, 1'b0, 27'h0, 4'h0, 1'b0, 2'd0, 40'h12_3456_7890, 1'b0, 64'h0},
    // R1 bypass of non-canonical address, bit 39 does not flag
    '{64'h0000_0880_0000_0005, 2'd0, 1'b0, 1'b0, 1'b0, 27'h0, 4'h0, 1'b0, 2'd0, 40'h80_0000_0004, 1'b0, 64'h0},
    // R2 non-canonical
    '{64'h0000_0800_0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 27'h0, 4'h0, 1'b0, 2'd1, 40'h0, 1'b0, PTB},
    // R2 top bit only, TLB would grant
    '{64'h8000_0000_0000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 27'h5, 4'hF, 1'b0, 2'd1, 40'h0, 1'b0, PTB},
    // R3 R8 superpage kernel, uncached
    '{64'hFFFF_FC80_1234_5678, 2'd0, 1'b1, 1'b0, 1'b0, 27'h0, 4'h0, 1'b0, 2'd0, 40'h80_1234_5678, 1'b1, 64'h0},
    // R3 superpage keeps low bits
    '{64'hFFFF_FC00_0000_A002, 2'd0, 1'b1, 1'b0, 1'b0, 27'h0, 4'h0, 1'b0, 2'd0, 40'h00_0000_A002, 1'b0, 64'h0},
    // R4 superpage user mode
    '{64'hFFFF_FC00_0000_A000, 2'd3, 1'b1, 1'b0, 1'b1, 27'h1, 4'hF, 1'b0, 2'd1, 40'h0, 1'b0, 64'h0000_1001_0000_0028},
    // R5 window disabled -> TLB miss
    '{64'hFFFF_FC00_0000_A000, 2'd0, 1'b0, 1'b0, 1'b0, 27'h0, 4'hF, 1'b1, 2'd2, 40'h0, 1'b0, 64'h0000_1001_0000_0028},
    // R6 hit, kernel
    '{64'h0000_0000_0004_6ABE, 2'd0, 1'b0, 1'b0, 1'b1, 27'h123, 4'b0001, 1'b1, 2'd0, 40'h00_0024_6ABC, 1'b0, 64'h0},
    // R6 R8 hit mode 2, uncached frame
    '{64'h0000_0000_0000_1FFC, 2'd2, 1'b0, 1'b0, 1'b1, 27'h400_0001, 4'b0100, 1'b1, 2'd0, 40'h80_0000_3FFC, 1'b1, 64'h0},
    // R7 mode 1 denied
    '{64'h0000_0000_0004_6ABE, 2'd1, 1'b0, 1'b0, 1'b1, 27'h123, 4'b1101, 1'b1, 2'd1, 40'h0, 1'b0, 64'h0000_1000_0000_0118},
    // R10 misspeculated miss
    '{64'h0000_0000_0001_0000, 2'd0, 1'b0, 1'b1, 1'b0, 27'h0, 4'h0, 1'b1, 2'd2, 40'h0, 1'b0, 64'h0},
    // R7 mode 3 granted
    '{64'h0000_0000_0004_6ABE, 2'd3, 1'b0, 1'b0, 1'b1, 27'h123, 4'b1000, 1'b1, 2'd0, 40'h00_0024_6ABC, 1'b0, 64'h0},
    // R2 negative canonical, outside window
    '{64'hFFFF_FFFF_FFFF_E000, 2'd0, 1'b1, 1'b0, 1'b1, 27'h1, 4'b0001, 1'b1, 2'd0, 40'h00_0000_2000, 1'b0, 64'h0}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_sp_en = 0, in_misspec = 0, out_ready = 1;
  logic [63:0] in_va = '0, pt_base = PTB, fault_tag, fault_form;
  logic [1:0]  in_mode = '0, out_fault;
  logic [7:0]  in_asn = 8'h5A, tlb_asn;
  logic        tlb_lookup, tlb_hit = 0, out_valid, out_uncached;
  logic [29:0] tlb_vpn;
  logic [26:0] tlb_pfn = '0;
  logic [3:0]  tlb_perm = '0;
  logic [39:0] out_pa;
  int checks = 0, fails = 0;
  logic [63:0] exp_tag = '0, exp_form = '0;

  always #2 clk = ~clk;

  iatu_fetch_xlate i_iatu_fetch_xlate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_va(in_va), .in_mode(in_mode), .in_sp_en(in_sp_en), .in_asn(in_asn),
    .in_misspec(in_misspec), .pt_base(pt_base), .tlb_lookup(tlb_lookup),
    .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
    .tlb_perm(tlb_perm), .out_valid(out_valid), .out_ready(out_ready),
    .out_pa(out_pa), .out_uncached(out_uncached), .out_fault(out_fault),
    .fault_tag(fault_tag), .fault_form(fault_form)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_va = v.va; in_mode = v.mode; in_sp_en = v.sp; in_misspec = v.ms;
    tlb_hit = v.hit; tlb_pfn = v.pfn; tlb_perm = v.perm; in_valid = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 out_valid", 64'(out_valid), 64'd0);
    chk("R12 fault_tag", fault_tag, 64'd0);
    chk("R12 fault_form", fault_form, 64'd0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      #1;
      chk($sformatf("R3/R5 lookup v%0d", k), 64'(tlb_lookup), 64'(VECS[k].exp_lk));
      if (k == 7) chk("R5 tlb_vpn", 64'(tlb_vpn), 64'h2000_0005);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (VECS[k].exp_flt != 2'd0 && !VECS[k].ms) begin
        exp_tag  = VECS[k].va;
        exp_form = VECS[k].exp_form;
      end
      chk($sformatf("R11 valid v%0d", k), 64'(out_valid), 64'd1);
      chk($sformatf("R1/R2/R4/R5/R7 fault v%0d", k), 64'(out_fault), 64'(VECS[k].exp_flt));
      if (VECS[k].exp_flt == 2'd0) begin
        chk($sformatf("R1/R3/R6 pa v%0d", k), 64'(out_pa), 64'(VECS[k].exp_pa));
        chk($sformatf("R8 uncached v%0d", k), 64'(out_uncached), 64'(VECS[k].exp_unc));
      end
      chk($sformatf("R9/R10 tag v%0d", k), fault_tag, exp_tag);
      chk($sformatf("R9/R10 form v%0d", k), fault_form, exp_form);
    end

    // R11 back-pressure: hold result, stall input
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[8]);
    @(posedge clk);
    @(negedge clk);
    drive(VECS[9]);
    #1;
    chk("R11 in_ready low", 64'(in_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R11 held pa", 64'(out_pa), 64'h00_0024_6ABC);
    chk("R11 held valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    #1;
    chk("R11 in_ready high", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 next pa", 64'(out_pa), 64'h80_0000_3FFC);
    @(posedge clk);
    @(negedge clk);
    chk("R11 drained", 64'(out_valid), 64'd0);

    // R12 reset again clears fault registers
    rst_n = 1'b0;
    #1;
    chk("R12 tag cleared", fault_tag, 64'd0);
    chk("R12 valid cleared", 64'(out_valid), 64'd0);
    finish_run();
  end
endmodule